// File: doc/BRIEF.md
# Window-Reuse Micro-Op Replay Decoder

This block is the middle stage of a three-level control decoder for one functional unit. It takes a single stream of 32-bit words. The first word of each packet is a header, and the words after it are the macro-ops of that packet. The block remaps each macro-op into a micro-op and keeps it in a local window store. It then issues the stored window again and again, in order, into a six-entry micro-op FIFO that feeds the unit's kernel controller. A short window can therefore stand for a long, regular micro-op sequence. One example is a unit that sends alternately to two destinations for many rounds.

While a window is being replayed, the input side is closed. Replay waits whenever the output FIFO is full. A header can ask for a final exit micro-op after its replays. A header with an illegal window length is reported on a one-cycle error pulse and then dropped.

Top module: `uop_window_replayer`

## Requirements
- R1: A header word carries the window length in bits [6:0], the reuse count in bits [22:7] and the exit flag in bit [23]; after a legal header exactly window-length further words are taken as macro-ops, and the next word after them is read as a header.
- R2: A macro-op word has its address in bits [31:12], its destination in bits [11:8] and its length in bits [7:0]. Its micro-op is 33 bits: bit 32 = 0, destination in [31:28], address in [27:8], length in [7:0].
- R3: The stored window is emitted in load order, one full pass per reuse. A window of 2 with a reuse of 128 gives 256 micro-ops that alternate between the two entries.
- R4: A reuse count of zero gives a single pass of the window.
- R5: A header whose window length is 0 or greater than 64 raises `err_o` for exactly one cycle. The header is discarded, no micro-op comes from it, and the next word is read as a header.
- R6: `in_ready` is low from the end of loading until the last micro-op of the packet (including any exit micro-op) has entered the output FIFO; it is high while a header or macro-op is awaited.
- R7: A header with the exit flag set adds, after its last replay, one micro-op with bit 32 = 1 and all other bits zero.
- R8: The output FIFO holds six micro-ops. While `out_ready` is low, replay stops once six are held, and no micro-op is lost, duplicated or reordered.
- R9: After reset `out_valid` and `err_o` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Header or macro-op word |
| out_valid | output | 1 | Micro-op available from the FIFO |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_uop | output | 33 | Micro-op (bit 32 marks exit) |
| err_o | output | 1 | One-cycle pulse on an illegal header |

## Verification
The main function is driven with several shapes of packet:
- A three-entry window with two passes checks order and field remapping.
- Two entries with 128 passes, under a stuttering consumer, separates true alternation from a stuck or skipped index.
- A zero reuse count separates "once" from "never" and "wrap-around".
- A full 64-entry window exercises the top store index.
- An exit-flagged packet checks that the exit micro-op comes exactly once and last.

Holding the consumer off around six-entry and seven-entry windows shows the FIFO depth at the ports. Windows of 0 and 65 are also sent, each followed by a legal packet, to check that error recovery leaves the parser aligned.

// File: rtl/uop_replay_pkg.sv
// Package: shared widths, field layouts and the macro-op remap for the
// window-reuse replay decoder. Assumes 32-bit input words.
package uop_replay_pkg;

    localparam int WORD_W  = 32;
    localparam int WLEN_W  = 7;
    localparam int REUSE_W = 16;
    localparam int BODY_W  = 32;
    localparam int UOP_W   = BODY_W + 1;

    // Stored micro-op body (exit bit is added on issue)
    typedef struct packed {
        logic [3:0]  dest;
        logic [19:0] addr;
        logic [7:0]  len;
    } uop_body_t;

    typedef struct packed {
        logic        last;
        logic [REUSE_W-1:0] reuse;
        logic [WLEN_W-1:0]  wlen;
    } hdr_t;

    // Header field extraction from a raw word
    function automatic hdr_t parse_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.wlen  = w[6:0];
        h.reuse = w[22:7];
        h.last  = w[23];
        return h;
    endfunction

    // Macro-op to micro-op field remap
    function automatic uop_body_t remap_mop(input logic [WORD_W-1:0] w);
        uop_body_t u;
        u.addr = w[31:12];
        u.dest = w[11:8];
        u.len  = w[7:0];
        return u;
    endfunction

endpackage

// File: rtl/uop_window_store.sv
// Window store: holds up to WIN_MAX micro-op bodies written during load and
// read asynchronously by index during replay. Assumes writes and reads never
// target the same entry in the same cycle (load and replay are exclusive).
module uop_window_store
    import uop_replay_pkg::*;
#(
    parameter int WIN_MAX = 64,
    localparam int IDX_W = $clog2(WIN_MAX)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  uop_body_t        wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output uop_body_t        rd_data
);

    uop_body_t mem_q [WIN_MAX];

    // Capture one loaded micro-op body
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Present the entry selected by the replay index
    always_comb begin
        rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/uop_out_fifo.sv
// Output FIFO between the replay decoder and the unit's micro-op consumer.
// DEPTH need not be a power of two. Assumes the writer honours full_o.
module uop_out_fifo #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 33,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic             full_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop;

    // Flags and read data derived from occupancy
    always_comb begin
        full_o  = (cnt_q == CNT_W'(DEPTH));
        valid_o = (cnt_q != '0);
        pop     = valid_o && ready_i;
        data_o  = mem_q[rd_ptr_q];
    end

    // Store pushed entries
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wr_ptr_q] <= push_data_i;
        end
    end

    // Pointer and occupancy update with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_i) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push_i, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i);

    // R8
    fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R8
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !push_i) |=> (valid_o && $stable(data_o)));

endmodule

// File: rtl/uop_replay_ctrl.sv
// Replay controller: parses headers, steers macro-ops into the window store,
// then walks the stored window reuse times into the output FIFO, adding an
// exit micro-op when asked. Assumes the store read is combinational.
module uop_replay_ctrl
    import uop_replay_pkg::*;
#(
    parameter int WIN_MAX = 64,
    localparam int IDX_W = $clog2(WIN_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output uop_body_t         st_wr_data,
    output logic [IDX_W-1:0]  st_rd_idx,
    input  uop_body_t         st_rd_data,
    output logic              push_o,
    output logic [UOP_W-1:0]  push_data_o,
    input  logic              fifo_full,
    output logic              err_o
);

    typedef enum logic [1:0] {S_HDR, S_LOAD, S_REPLAY, S_EXIT} state_t;

    state_t             state_q;
    logic [WLEN_W-1:0]  wlen_q, idx_q;
    logic [REUSE_W-1:0] reps_q, rep_q;
    logic               last_q, err_q;
    logic               fire, hdr_bad, idx_end, rep_end;
    hdr_t               hdr;

    // Input handshake and header decode
    always_comb begin
        in_ready = (state_q == S_HDR) || (state_q == S_LOAD);
        fire     = in_valid && in_ready;
        hdr      = parse_hdr(in_data);
        hdr_bad  = (hdr.wlen == '0) || (hdr.wlen > WLEN_W'(WIN_MAX));
        idx_end  = (idx_q == wlen_q - 1'b1);
        rep_end  = (rep_q == reps_q - 1'b1);
    end

    // Store write and read port steering
    always_comb begin
        st_wr_en   = (state_q == S_LOAD) && fire;
        st_wr_idx  = idx_q[IDX_W-1:0];
        st_wr_data = remap_mop(in_data);
        st_rd_idx  = idx_q[IDX_W-1:0];
    end

    // Output push selection
    always_comb begin
        push_o      = ((state_q == S_REPLAY) || (state_q == S_EXIT)) && !fifo_full;
        push_data_o = (state_q == S_EXIT) ? {1'b1, {BODY_W{1'b0}}}
                                          : {1'b0, st_rd_data};
    end

    assign err_o = err_q;

    // Sequencing of header, load, replay and exit phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HDR;
            wlen_q  <= '0;
            reps_q  <= '0;
            last_q  <= 1'b0;
            idx_q   <= '0;
            rep_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (state_q == S_HDR) && fire && hdr_bad;
            case (state_q)
                S_HDR: begin
                    if (fire && !hdr_bad) begin
                        wlen_q  <= hdr.wlen;
                        reps_q  <= (hdr.reuse == '0) ? REUSE_W'(1) : hdr.reuse;
                        last_q  <= hdr.last;
                        idx_q   <= '0;
                        state_q <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    if (fire) begin
                        if (idx_end) begin
                            idx_q   <= '0;
                            rep_q   <= '0;
                            state_q <= S_REPLAY;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_REPLAY: begin
                    if (!fifo_full) begin
                        if (idx_end) begin
                            idx_q <= '0;
                            if (rep_end) begin
                                state_q <= last_q ? S_EXIT : S_HDR;
                            end else begin
                                rep_q <= rep_q + 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_EXIT: begin
                    if (!fifo_full) begin
                        state_q <= S_HDR;
                    end
                end
                default: state_q <= S_HDR;
            endcase
        end
    end

    // R1
    load_idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> (idx_q < wlen_q));

    // R3
    replay_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && !push_data_o[UOP_W-1]) |-> (rep_q < reps_q));

    // R5
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R7
    exit_only_when_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_data_o[UOP_W-1]) |-> last_q);

    // R6
    closed_during_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && !push_data_o[UOP_W-1] && !(idx_end && rep_end)) |=> !in_ready);

endmodule

// File: rtl/uop_window_replayer.sv
// Top: second-level window-reuse decoder for one unit type. Joins the replay
// controller, the local window store and the six-deep micro-op output FIFO.
// Assumes the input stream alternates headers and their macro-op windows.
module uop_window_replayer
    import uop_replay_pkg::*;
#(
    parameter int WIN_MAX    = 64,
    parameter int FIFO_DEPTH = 6,
    localparam int IDX_W = $clog2(WIN_MAX)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [32:0] out_uop,
    output logic        err_o
);

    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx, st_rd_idx;
    uop_body_t        st_wr_data, st_rd_data;
    logic             push, fifo_full;
    logic [UOP_W-1:0] push_data;

    uop_replay_ctrl #(.WIN_MAX(WIN_MAX)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .st_wr_en   (st_wr_en),
        .st_wr_idx  (st_wr_idx),
        .st_wr_data (st_wr_data),
        .st_rd_idx  (st_rd_idx),
        .st_rd_data (st_rd_data),
        .push_o     (push),
        .push_data_o(push_data),
        .fifo_full  (fifo_full),
        .err_o      (err_o)
    );

    uop_window_store #(.WIN_MAX(WIN_MAX)) store_i (
        .clk    (clk),
        .wr_en  (st_wr_en),
        .wr_idx (st_wr_idx),
        .wr_data(st_wr_data),
        .rd_idx (st_rd_idx),
        .rd_data(st_rd_data)
    );

    uop_out_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(UOP_W)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_data_i(push_data),
        .full_o     (fifo_full),
        .valid_o    (out_valid),
        .ready_i    (out_ready),
        .data_o     (out_uop)
    );

endmodule

// File: tb/uop_window_replayer_tb_top.sv
// Bench: behavioural queue model of expected micro-ops, compared on every
// clock at the output handshake; directed packets cover each requirement.
module uop_window_replayer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready;
    logic [32:0] out_uop;
    logic        err_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ready_mode = 0;
    logic [32:0] exp_q [$];

    uop_window_replayer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_uop(out_uop), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // consumer readiness pattern, changed just after each rising edge
    initial out_ready = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model comparison at every output transfer (R2 R3 R8)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected uop", out_uop, '0);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                check(out_uop == e, "R3 uop order/value", out_uop, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic [31:0] mk_mop(input int i, input int base);
        logic [19:0] a;
        logic [3:0]  d;
        logic [7:0]  l;
        a = 20'(base + i * 17);
        d = 4'(i);
        l = 8'(i * 3 + 1);
        return {a, d, l};
    endfunction

    task automatic send_word(input logic [31:0] w);
        bit acc;
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_data  = w;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #2;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    // R1 R2 R4 R7: send one packet and enqueue its expected micro-ops
    task automatic send_packet(input int wl, input int reuse, input bit last, input int base);
        int reps;
        reps = (reuse == 0) ? 1 : reuse;
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i < wl; i++) begin
                logic [31:0] m;
                m = mk_mop(i, base);
                exp_q.push_back({1'b0, m[11:8], m[31:12], m[7:0]});
            end
        end
        if (last) exp_q.push_back({1'b1, 32'b0});
        send_word({8'h0, last, 16'(reuse), 7'(wl)});
        for (int i = 0; i < wl; i++) begin
            send_word(mk_mop(i, base));
        end
    endtask

    task automatic drain(input string req);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(!out_valid, req, {32'b0, out_valid}, 33'd0);
        check(in_ready, req, {32'b0, in_ready}, 33'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(!out_valid && !err_o && in_ready, "R9 reset outputs",
              {30'b0, out_valid, err_o, in_ready}, 33'd1);
        rst_n = 1'b1;

        // R1 R2 R3 basic window
        send_packet(3, 2, 1'b0, 100);
        drain("R1 basic packet end");

        // R3 alternation 2 x 128 with stuttering consumer
        ready_mode = 1;
        send_packet(2, 128, 1'b0, 4000);
        drain("R3 alternation end");
        ready_mode = 0;

        // R4 reuse zero gives one pass
        send_packet(4, 0, 1'b0, 777);
        drain("R4 single pass end");

        // R7 exit micro-op after replays
        send_packet(2, 3, 1'b1, 50);
        drain("R7 exit end");

        // R5 oversize window
        send_word({8'h0, 1'b1, 16'd2, 7'd65});
        @(negedge clk);
        check(err_o, "R5 err pulse oversize", {32'b0, err_o}, 33'd1);
        @(negedge clk);
        check(!err_o, "R5 err single cycle", {32'b0, err_o}, 33'd0);
        check(!out_valid && in_ready, "R5 no output, header awaited",
              {31'b0, out_valid, in_ready}, 33'd1);
        // R5 zero window
        send_word({8'h0, 1'b0, 16'd1, 7'd0});
        @(negedge clk);
        check(err_o, "R5 err pulse zero window", {32'b0, err_o}, 33'd1);
        // R5 recovery: next word is a header
        send_packet(1, 2, 1'b1, 9);
        drain("R5 recovery packet");

        // R1 full 64-entry window
        send_packet(64, 2, 1'b0, 12345);
        drain("R1 max window end");

        // R8 depth: six fit with consumer stalled
        ready_mode = 2;
        send_packet(6, 1, 1'b0, 300);
        repeat (20) @(negedge clk);
        check(in_ready, "R8 six entries fit", {32'b0, in_ready}, 33'd1);
        // R6 R8 a seventh cannot enter, input stays closed
        send_packet(7, 1, 1'b0, 600);
        repeat (20) @(negedge clk);
        check(!in_ready, "R6 input closed while replay pending", {32'b0, in_ready}, 33'd0);
        check(out_valid, "R8 held data valid", {32'b0, out_valid}, 33'd1);
        ready_mode = 0;
        drain("R8 drain after stall");

        check(exp_q.size() == 0, "R3 model queue empty", 33'(exp_q.size()), 33'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule